// File: doc/BRIEF.md
# Byte-Rewritable Nonvolatile Store Controller

This block lets a processor treat a small nonvolatile-style byte store as if it were RAM. Reads behave like an ordinary synchronous memory: the addressed byte appears on the read bus one clock after the request. A write to a single byte is not applied at once. It starts an internal sequence that clears the byte to the erased value 0xFF and afterwards programs the new value. The controller reports busy for a long, parameterised number of clock cycles while this runs.

Writes are only taken when a programming-power enable input is high and no earlier write is still in progress. Every location has its own wear counter. A location that has used up its allowed number of write cycles refuses further writes. Such a refused write raises an error flag that stays set until reset, and the stored byte is left as it was. The byte store is a register array held inside the block.

Top module: `nvm_byte_store`

## Requirements
- R1: After reset, busy and wearError are low and every location reads 0xFF.
- R2: A write request (cpuSel=1, cpuWrite=1) made while idle, with progPowerEn=1, to a location whose wear count is below ENDURANCE is accepted. busy rises on the next clock edge and stays high for exactly ERASE_CYC+PROG_CYC cycles.
- R3: Once busy has fallen after an accepted write, reading the written address returns the new byte.
- R4: From the first busy cycle until busy falls, a read of the location being rewritten returns 0xFF.
- R5: While busy, a read of any other location returns its previously stored byte.
- R6: A write request made while busy is ignored. It changes no stored byte, does not extend the busy period and does not count as wear.
- R7: A write request made with progPowerEn=0 is ignored. busy stays low, the data is unchanged and wearError is not set.
- R8: Each location accepts exactly ENDURANCE writes. A further powered write request to it while idle leaves busy low, leaves the byte unchanged and sets wearError on the next edge.
- R9: wearError stays high until reset. Wear is counted per location, so other locations remain writable after one location wears out.
- R10: rdData is loaded with the addressed byte one edge after a read request (cpuSel=1, cpuWrite=0) and holds its value in every other cycle, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Access request for this cycle |
| cpuWrite | input | 1 | 1 = write request, 0 = read request |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 8 | Byte to write |
| progPowerEn | input | 1 | Programming power enable; writes are accepted only when high |
| rdData | output | 8 | Registered read data |
| busy | output | 1 | High while an erase/program sequence runs |
| wearError | output | 1 | Sticky flag: a write was refused because a location was worn out |

## Verification
The bench builds the block with 16 locations, a 4-cycle erase phase, a 5-cycle program phase and an endurance limit of 3. With these values a full write sequence lasts 9 cycles, so the bench can issue reads and write attempts at known points inside a busy window. The small endurance limit lets it wear out one location after three accepted writes. The bench also shows that a write ignored while busy does not use up one of those three writes, and that a neighbouring location is still writable afterwards.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2
  } nvm_phase_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic latch;   // capture target, erase byte, consume one wear count
    logic commit;  // program latched byte into latched address
    logic refuse;  // write refused for wear, raise sticky error
  } nvm_strobe_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ERASE_CYC = 62500,
  parameter int PROG_CYC  = 62500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuSel,
  input  logic        cpuWrite,
  input  logic        progPowerEn,
  input  logic        wornOut,
  output nvm_strobe_t strb,
  output logic        busy
);

  localparam int MAX_CYC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int TMR_W    = $clog2(MAX_CYC) + 1;
  localparam int TOTAL    = ERASE_CYC + PROG_CYC;
  localparam int LEN_W    = $clog2(TOTAL + 1) + 1;

  nvm_phase_e phase;
  logic [TMR_W-1:0] timer;
  logic writeReq;
  logic timerDone;

  assign writeReq  = cpuSel && cpuWrite && progPowerEn && (phase == PH_IDLE);
  assign timerDone = (timer == '0);

  always_comb begin
    strb        = '0;
    strb.latch  = writeReq && !wornOut;
    strb.refuse = writeReq && wornOut;
    strb.commit = (phase == PH_PROG) && timerDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      timer <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (strb.latch) begin
            phase <= PH_ERASE;
            timer <= TMR_W'(ERASE_CYC - 1);
          end
        end
        PH_ERASE: begin
          if (timerDone) begin
            phase <= PH_PROG;
            timer <= TMR_W'(PROG_CYC - 1);
          end else begin
            timer <= timer - 1'b1;
          end
        end
        PH_PROG: begin
          if (timerDone) begin
            phase <= PH_IDLE;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase != PH_IDLE);

  // length of current busy run, used only by the checks below
  logic [LEN_W-1:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == LEN_W'(TOTAL)));

  p_end_by_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strb.commit));

  p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.latch && !strb.refuse);

  p_power_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(progPowerEn) && $past(cpuSel && cpuWrite));

endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int ENDURANCE = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  input  nvm_strobe_t       strb,
  output logic              wornOut,
  output logic [7:0]        rdData,
  output logic              wearError
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WEAR_W = $clog2(ENDURANCE + 1);

  logic [7:0]        memArr  [DEPTH];
  logic [WEAR_W-1:0] wearCnt [DEPTH];
  logic [ADDR_W-1:0] tgtAddr;
  logic [7:0]        tgtData;

  assign wornOut = (wearCnt[cpuAddr] >= WEAR_W'(ENDURANCE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtAddr <= '0;
      tgtData <= ERASED_BYTE;
    end else if (strb.latch) begin
      tgtAddr <= cpuAddr;
      tgtData <= cpuWdata;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_loc
    logic hitNew;
    logic hitOld;
    assign hitNew = strb.latch && (cpuAddr == ADDR_W'(gi));
    assign hitOld = strb.commit && (tgtAddr == ADDR_W'(gi));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        memArr[gi]  <= ERASED_BYTE;
        wearCnt[gi] <= '0;
      end else begin
        if (hitNew) begin
          memArr[gi]  <= ERASED_BYTE;
          wearCnt[gi] <= wearCnt[gi] + 1'b1;
        end else if (hitOld) begin
          memArr[gi]  <= tgtData;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= ERASED_BYTE;
    else if (cpuSel && !cpuWrite) rdData <= memArr[cpuAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) wearError <= 1'b0;
    else if (strb.refuse) wearError <= 1'b1;
  end

  p_erase_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |=> (memArr[tgtAddr] == ERASED_BYTE));

  p_wear_limit_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |-> (wearCnt[cpuAddr] < WEAR_W'(ENDURANCE)));

  p_error_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    wearError |=> wearError);

endmodule

// File: rtl/nvm_byte_store.sv
module nvm_byte_store
  import nvm_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int ERASE_CYC = 62500,
  parameter int PROG_CYC  = 62500,
  parameter int ENDURANCE = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  input  logic              progPowerEn,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              wearError
);

  nvm_strobe_t strb;
  logic wornOut;

  nvm_ctrl #(
    .ERASE_CYC(ERASE_CYC),
    .PROG_CYC (PROG_CYC)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuSel     (cpuSel),
    .cpuWrite   (cpuWrite),
    .progPowerEn(progPowerEn),
    .wornOut    (wornOut),
    .strb       (strb),
    .busy       (busy)
  );

  nvm_datapath #(
    .ADDR_W   (ADDR_W),
    .ENDURANCE(ENDURANCE)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cpuSel   (cpuSel),
    .cpuWrite (cpuWrite),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .strb     (strb),
    .wornOut  (wornOut),
    .rdData   (rdData),
    .wearError(wearError)
  );

  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cpuSel && !cpuWrite) |-> $stable(rdData));

endmodule

// File: tb/test_nvm_byte_store.sv
module test_nvm_byte_store;

  localparam int ADDR_W = 4;
  localparam int ER     = 4;
  localparam int PR     = 5;
  localparam int ENDUR  = 3;
  localparam int TOTAL  = ER + PR;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuSel = 1'b0;
  logic cpuWrite = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0;
  logic progPowerEn = 1'b1;
  logic [7:0] rdData;
  logic busy;
  logic wearError;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  nvm_byte_store #(
    .ADDR_W(ADDR_W), .ERASE_CYC(ER), .PROG_CYC(PR), .ENDURANCE(ENDUR)
  ) i_nvm_byte_store (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .progPowerEn(progPowerEn),
    .rdData(rdData), .busy(busy), .wearError(wearError)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuSel = 1'b1; cpuWrite = 1'b1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuSel = 1'b0; cpuWrite = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpuSel = 1'b1; cpuWrite = 1'b0; cpuAddr = a;
    @(negedge clk);
    cpuSel = 1'b0;
    d = rdData;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic readChk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    doRead(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(wearError == 1'b0, "R1 wearError", wearError, 0);
    readChk(4'd0, 8'hFF, "R1 addr0");
    readChk(4'd9, 8'hFF, "R1 addr9");
    readChk(4'd15, 8'hFF, "R1 addr15");
  endtask

  task automatic t_basic();
    int n;
    doWrite(4'd1, 8'h3C);
    chk(busy == 1'b1, "R2 busy rise", busy, 1);
    waitIdle(n);
    chk(n == TOTAL, "R2 busy length", n, TOTAL);
    readChk(4'd1, 8'h3C, "R3 readback");
    doWrite(4'd4, 8'h11);
    waitIdle(n);
    chk(n == TOTAL, "R2 busy length addr4", n, TOTAL);
    readChk(4'd4, 8'h11, "R3 readback addr4");
  endtask

  task automatic t_busyRead();
    int n;
    doWrite(4'd1, 8'hA5);
    readChk(4'd1, 8'hFF, "R4 target erased");
    readChk(4'd4, 8'h11, "R5 other old data");
    readChk(4'd1, 8'hFF, "R4 target still erased");
    waitIdle(n);
    chk(n == TOTAL - 6, "R2 busy length with reads", n, TOTAL - 6);
    readChk(4'd1, 8'hA5, "R3 readback after busy");
  endtask

  task automatic t_busyIgnore();
    int n;
    doWrite(4'd2, 8'h55);
    doWrite(4'd2, 8'h66);
    doWrite(4'd4, 8'h99);
    waitIdle(n);
    chk(n == TOTAL - 4, "R6 busy not extended", n, TOTAL - 4);
    readChk(4'd2, 8'h55, "R6 target unchanged");
    readChk(4'd4, 8'h11, "R6 other unchanged");
  endtask

  task automatic t_power();
    readChk(4'd1, 8'hA5, "R10 read before hold");
    progPowerEn = 1'b0;
    doWrite(4'd3, 8'h00);
    chk(busy == 1'b0, "R7 busy stays low", busy, 0);
    chk(wearError == 1'b0, "R7 no error", wearError, 0);
    chk(rdData == 8'hA5, "R10 rdData holds over write", rdData, 8'hA5);
    progPowerEn = 1'b1;
    readChk(4'd3, 8'hFF, "R7 data unchanged");
  endtask

  task automatic t_wear();
    int n;
    doWrite(4'd2, 8'h70);
    waitIdle(n);
    chk(n == TOTAL, "R8 second write accepted", n, TOTAL);
    doWrite(4'd2, 8'h71);
    waitIdle(n);
    chk(n == TOTAL, "R8 third write accepted", n, TOTAL);
    chk(wearError == 1'b0, "R8 no error at limit", wearError, 0);
    doWrite(4'd2, 8'h72);
    chk(busy == 1'b0, "R8 refused no busy", busy, 0);
    chk(wearError == 1'b1, "R8 error set", wearError, 1);
    readChk(4'd2, 8'h71, "R8 data unchanged");
    doWrite(4'd6, 8'h42);
    waitIdle(n);
    chk(n == TOTAL, "R9 other location writable", n, TOTAL);
    readChk(4'd6, 8'h42, "R9 other location data");
    chk(wearError == 1'b1, "R9 error sticky", wearError, 1);
    doWrite(4'd2, 8'h73);
    chk(busy == 1'b0, "R8 still refused", busy, 0);
    readChk(4'd2, 8'h71, "R8 data still unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busyRead();
    t_busyIgnore();
    t_power();
    t_wear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule